// File: doc/BRIEF.md
# Flash Page Program-Verify Sequencer

This block writes one page of target data into a flash array. It does this by repeating a loop of write pulses, and each pulse is followed by a verify read of the whole page. Software first fills the page target through a byte load port while the block is idle, then raises `start`. The block walks the page and loads each byte into the array's write latch, where a 0 bit means that bit is pulsed. It then holds `fl_pulse` for a width chosen from the loop number and reads the page back. From the read data it works out what the next loop must pulse.

Three byte stores sit next to the target page. The reprogram store holds the latch image for the next main pulse. The extra store holds the latch image for a short additional-programming pulse. The seen store marks each bit that has ever verified as programmed. The extra pass runs only in early loops, and only for bits whose first verify happened in that loop. The sequence ends when no target-zero bit still reads 1, or when the loop limit is reached. The end is reported by a one-cycle `done`, and `fail` is valid in the same cycle.

States:
- `ST_IDLE` goes to `ST_INIT` on `start`.
- `ST_INIT` copies the target page to the reprogram store and clears the seen store, then goes to `ST_LATCH`.
- `ST_LATCH` writes the reprogram image into the array latch, then goes to `ST_PULSE`.
- `ST_PULSE` holds the main pulse, then goes to `ST_VERIFY`.
- `ST_VERIFY` reads the page back and updates the stores. It then goes to `ST_XLATCH` if the loop is early and some bit verified for the first time. Otherwise it goes to `ST_CHECK`.
- `ST_XLATCH` writes the extra image into the array latch, then goes to `ST_XPULSE`.
- `ST_XPULSE` holds the short pulse, then goes to `ST_CHECK`.
- `ST_CHECK` goes to `ST_DONE` when the page is complete or the limit is reached. Otherwise it goes back to `ST_LATCH`.
- `ST_DONE` goes to `ST_IDLE`.

Top module: `flpv_sequencer`

## Requirements
- R1: A byte on `ld_data` is stored at `ld_addr` of the target page only while `busy` is low; `ld_en` during a run has no effect on what is programmed.
- R2: `start` in idle begins a run and raises `busy`; `start` while busy is ignored. `done` is high for exactly one cycle, `fail` is high only together with `done`, and `busy` is low in the cycle after `done`.
- R3: Each latch pass asserts `fl_wr` for bytes 0 to PAGE_BYTES-1 in order, never together with `fl_pulse`. A 0 in `fl_wdata` means the bit is pulsed, and the first loop's latch image equals the target page.
- R4: The main pulse lasts CLK_MHZ*SHORT_US cycles in loops 1 to EARLY_LOOPS (default 6), and CLK_MHZ*LONG_US cycles in later loops.
- R5: After each main pulse the page is read back. A target-zero bit that reads 0 is programmed. The next loop's latch image has 0 exactly at the target-zero bits that read 1.
- R6: A bit whose target value is 1 is never written as 0 into the array latch.
- R7: In a loop n ≤ EARLY_LOOPS, if some bit verified as 0 for the first time, an extra latch pass follows the verify. Its image has 0 only at those bits, and it is followed by one pulse of CLK_MHZ*EXTRA_US cycles.
- R8: Loops beyond EARLY_LOOPS never produce an extra pass, even when bits first verify in them.
- R9: A bit that verified earlier and reads 1 in a later verify is written as 0 in the next latch image. When it verifies again it gets no second extra pulse.
- R10: When every target-zero bit reads 0, the run ends after any extra pass of that loop, with `fail` low, and the array holds the target page.
- R11: If bits remain unprogrammed after loop MAX_LOOPS, the run ends with `fail` high, and no more than MAX_LOOPS main pulses are issued.
- R12: After reset `busy`, `done`, `fail`, `fl_wr` and `fl_pulse` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a program run (idle only) |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run strobe |
| fail | output | 1 | Run ended without full verify; valid with `done` |
| ld_en | input | 1 | Target page byte write enable |
| ld_addr | input | ADDR_W | Target page byte index |
| ld_data | input | 8 | Target page byte value |
| fl_addr | output | ADDR_W | Array byte index for latch write and verify read |
| fl_wdata | output | 8 | Latch byte, 0 = pulse this bit |
| fl_wr | output | 1 | Latch byte write strobe |
| fl_pulse | output | 1 | Write pulse, held for the pulse width |
| fl_rdata | input | 8 | Array read data for `fl_addr`, same cycle |

## Verification
Two events can fall in the same loop: the final verify that completes the page, and the first verify of bits that still need the short extra pulse. A page is set up whose last bits finish in an early loop. A correct run must then emit a short pulse after that loop's main pulse and before `done`. The bench judges this from the recorded pulse-width sequence and the zero count of the final latch pass. A second case puts a regression and a first verify in nearby loops. The bench checks that the regressed bit is pulsed again and is left out of the later extra image.

// File: rtl/flpv_pkg.sv
package flpv_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_INIT,
        ST_LATCH,
        ST_PULSE,
        ST_VERIFY,
        ST_XLATCH,
        ST_XPULSE,
        ST_CHECK,
        ST_DONE
    } flpv_state_e;
endpackage

// File: rtl/flpv_byte_ram.sv
module flpv_byte_ram #(
    parameter int DEPTH = 128,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/flpv_pulse_timer.sv
module flpv_pulse_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          zero
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/flpv_bit_merge.sv
module flpv_bit_merge (
    input  logic [7:0] tgt,
    input  logic [7:0] rd,
    input  logic [7:0] seen_old,
    output logic [7:0] reprog_byte,
    output logic [7:0] add_byte,
    output logic [7:0] seen_new,
    output logic       pending,
    output logic       fresh
);
    logic [7:0] want0;
    logic [7:0] ok0;
    logic [7:0] first0;

    always_comb begin
        want0       = ~tgt;
        ok0         = want0 & ~rd;
        first0      = ok0 & ~seen_old;
        reprog_byte = ~(want0 & rd);
        add_byte    = ~first0;
        seen_new    = seen_old | ok0;
        pending     = |(want0 & rd);
        fresh       = |first0;
    end
endmodule

// File: rtl/flpv_sequencer.sv
module flpv_sequencer
    import flpv_pkg::*;
#(
    parameter int PAGE_BYTES  = 128,
    parameter int MAX_LOOPS   = 1000,
    parameter int CLK_MHZ     = 100,
    parameter int SHORT_US    = 30,
    parameter int LONG_US     = 200,
    parameter int EXTRA_US    = 10,
    parameter int EARLY_LOOPS = 6,
    localparam int ADDR_W     = $clog2(PAGE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              busy,
    output logic              done,
    output logic              fail,
    input  logic              ld_en,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [7:0]        ld_data,
    output logic [ADDR_W-1:0] fl_addr,
    output logic [7:0]        fl_wdata,
    output logic              fl_wr,
    output logic              fl_pulse,
    input  logic [7:0]        fl_rdata
);
    localparam int LOOP_W    = $clog2(MAX_LOOPS + 1);
    localparam int SHORT_CYC = CLK_MHZ * SHORT_US;
    localparam int LONG_CYC  = CLK_MHZ * LONG_US;
    localparam int EXTRA_CYC = CLK_MHZ * EXTRA_US;
    localparam int BIG_A     = (SHORT_CYC > LONG_CYC) ? SHORT_CYC : LONG_CYC;
    localparam int BIG_CYC   = (BIG_A > EXTRA_CYC) ? BIG_A : EXTRA_CYC;
    localparam int TMR_W     = $clog2(BIG_CYC + 1);
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(PAGE_BYTES - 1);

    flpv_state_e state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [LOOP_W-1:0] loop_q;
    logic              pend_q, fresh_q, fail_q;

    logic              last_addr, early, walking, tmr_zero, tmr_load;
    logic [TMR_W-1:0]  tmr_val;
    logic [7:0]        tgt_rd, rep_rd, add_rd, seen_rd;
    logic [7:0]        m_rep, m_add, m_seen;
    logic              m_pend, m_fresh;
    logic              rep_we, seen_we;
    logic [7:0]        rep_wd, seen_wd;

    assign last_addr = (addr_q == LAST_ADDR);
    assign early     = (loop_q <= LOOP_W'(EARLY_LOOPS));
    assign walking   = (state_q == ST_INIT) || (state_q == ST_LATCH) ||
                       (state_q == ST_VERIFY) || (state_q == ST_XLATCH);

    // ---------------- page stores ----------------
    flpv_byte_ram #(.DEPTH(PAGE_BYTES), .AW(ADDR_W)) u_tgt_ram (
        .clk   (clk),
        .we    (ld_en && (state_q == ST_IDLE)),
        .waddr (ld_addr),
        .wdata (ld_data),
        .raddr (addr_q),
        .rdata (tgt_rd)
    );

    assign rep_we  = (state_q == ST_INIT) || (state_q == ST_VERIFY);
    assign rep_wd  = (state_q == ST_INIT) ? tgt_rd : m_rep;
    assign seen_we = rep_we;
    assign seen_wd = (state_q == ST_INIT) ? 8'h00 : m_seen;

    flpv_byte_ram #(.DEPTH(PAGE_BYTES), .AW(ADDR_W)) u_rep_ram (
        .clk   (clk),
        .we    (rep_we),
        .waddr (addr_q),
        .wdata (rep_wd),
        .raddr (addr_q),
        .rdata (rep_rd)
    );

    flpv_byte_ram #(.DEPTH(PAGE_BYTES), .AW(ADDR_W)) u_add_ram (
        .clk   (clk),
        .we    (state_q == ST_VERIFY),
        .waddr (addr_q),
        .wdata (m_add),
        .raddr (addr_q),
        .rdata (add_rd)
    );

    flpv_byte_ram #(.DEPTH(PAGE_BYTES), .AW(ADDR_W)) u_seen_ram (
        .clk   (clk),
        .we    (seen_we),
        .waddr (addr_q),
        .wdata (seen_wd),
        .raddr (addr_q),
        .rdata (seen_rd)
    );

    flpv_bit_merge u_merge (
        .tgt         (tgt_rd),
        .rd          (fl_rdata),
        .seen_old    (seen_rd),
        .reprog_byte (m_rep),
        .add_byte    (m_add),
        .seen_new    (m_seen),
        .pending     (m_pend),
        .fresh       (m_fresh)
    );

    // ---------------- pulse timer ----------------
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = '0;
        if ((state_q == ST_LATCH) && last_addr) begin
            tmr_load = 1'b1;
            tmr_val  = early ? TMR_W'(SHORT_CYC - 1) : TMR_W'(LONG_CYC - 1);
        end else if ((state_q == ST_XLATCH) && last_addr) begin
            tmr_load = 1'b1;
            tmr_val  = TMR_W'(EXTRA_CYC - 1);
        end
    end

    flpv_pulse_timer #(.CW(TMR_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_INIT;
            ST_INIT:   if (last_addr) state_d = ST_LATCH;
            ST_LATCH:  if (last_addr) state_d = ST_PULSE;
            ST_PULSE:  if (tmr_zero) state_d = ST_VERIFY;
            ST_VERIFY: begin
                if (last_addr) begin
                    state_d = (early && (fresh_q || m_fresh)) ? ST_XLATCH : ST_CHECK;
                end
            end
            ST_XLATCH: if (last_addr) state_d = ST_XPULSE;
            ST_XPULSE: if (tmr_zero) state_d = ST_CHECK;
            ST_CHECK: begin
                if (!pend_q || (loop_q == LOOP_W'(MAX_LOOPS))) begin
                    state_d = ST_DONE;
                end else begin
                    state_d = ST_LATCH;
                end
            end
            ST_DONE:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // ---------------- datapath registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            loop_q  <= '0;
            pend_q  <= 1'b0;
            fresh_q <= 1'b0;
            fail_q  <= 1'b0;
        end else begin
            if (walking) begin
                addr_q <= last_addr ? '0 : addr_q + 1'b1;
            end else begin
                addr_q <= '0;
            end

            if ((state_q == ST_IDLE) && start) begin
                loop_q <= LOOP_W'(1);
            end else if ((state_q == ST_CHECK) && (state_d == ST_LATCH)) begin
                loop_q <= loop_q + 1'b1;
            end

            if (state_q == ST_LATCH) begin
                pend_q  <= 1'b0;
                fresh_q <= 1'b0;
            end else if (state_q == ST_VERIFY) begin
                pend_q  <= pend_q | m_pend;
                fresh_q <= fresh_q | m_fresh;
            end

            if (state_q == ST_CHECK) begin
                fail_q <= pend_q;
            end
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        busy     = (state_q != ST_IDLE);
        done     = (state_q == ST_DONE);
        fail     = (state_q == ST_DONE) && fail_q;
        fl_addr  = addr_q;
        fl_wr    = (state_q == ST_LATCH) || (state_q == ST_XLATCH);
        fl_pulse = (state_q == ST_PULSE) || (state_q == ST_XPULSE);
        fl_wdata = 8'hFF;
        if (state_q == ST_LATCH) begin
            fl_wdata = rep_rd;
        end else if (state_q == ST_XLATCH) begin
            fl_wdata = add_rd;
        end
    end
endmodule

// File: rtl/flpv_sequencer_chk.sv
module flpv_sequencer_chk #(
    parameter int LOOP_W      = 10,
    parameter int MAX_LOOPS   = 1000,
    parameter int EARLY_LOOPS = 6,
    parameter int SHORT_CYC   = 3000,
    parameter int LONG_CYC    = 20000,
    parameter int EXTRA_CYC   = 1000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              fail,
    input logic              fl_wr,
    input logic              fl_pulse,
    input logic [LOOP_W-1:0] loop_q
);
    int unsigned len_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q <= 0;
        end else begin
            len_q <= fl_pulse ? len_q + 1 : 0;
        end
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R2
    AST_FAIL_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> done); // R2
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!fl_pulse && !fl_wr)); // R12
    AST_WR_PULSE_APART: assert property (@(posedge clk) disable iff (!rst_n)
        !(fl_wr && fl_pulse)); // R3
    AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fl_pulse) |-> ((len_q == SHORT_CYC) || (len_q == LONG_CYC) || (len_q == EXTRA_CYC))); // R4
    AST_LONG_ONLY_LATE: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(fl_pulse) && (len_q == LONG_CYC)) |-> (loop_q > LOOP_W'(EARLY_LOOPS))); // R4
    AST_EXTRA_ONLY_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(fl_pulse) && (len_q == EXTRA_CYC)) |-> (loop_q <= LOOP_W'(EARLY_LOOPS))); // R8
    AST_LOOP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        loop_q <= LOOP_W'(MAX_LOOPS)); // R11
endmodule

bind flpv_sequencer flpv_sequencer_chk #(
    .LOOP_W      (LOOP_W),
    .MAX_LOOPS   (MAX_LOOPS),
    .EARLY_LOOPS (EARLY_LOOPS),
    .SHORT_CYC   (SHORT_CYC),
    .LONG_CYC    (LONG_CYC),
    .EXTRA_CYC   (EXTRA_CYC)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .done     (done),
    .fail     (fail),
    .fl_wr    (fl_wr),
    .fl_pulse (fl_pulse),
    .loop_q   (loop_q)
);

// File: tb/flpv_sequencer_bench.sv
`timescale 1ns/1ps
module flpv_sequencer_bench;
    localparam int PB = 128;
    localparam int AW = 7;
    localparam int SH = 30;
    localparam int LG = 200;
    localparam int XT = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          busy, done, fail;
    logic          ld_en = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic [7:0]    ld_data = '0;
    logic [AW-1:0] fl_addr;
    logic [7:0]    fl_wdata;
    logic          fl_wr, fl_pulse;
    logic [7:0]    fl_rdata;

    always #5 clk = ~clk;

    flpv_sequencer #(.PAGE_BYTES(PB), .MAX_LOOPS(10), .CLK_MHZ(1)) u_flpv_sequencer (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .fail(fail),
        .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
        .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_wr(fl_wr), .fl_pulse(fl_pulse),
        .fl_rdata(fl_rdata)
    );

    // ---------------- flash array model ----------------
    logic [7:0] mem [PB];
    logic [7:0] lat [PB];
    logic [7:0] tgt [PB];
    int need [PB*8];
    int got  [PB*8];
    int plen, npulse, wcount, viol, done_cnt, weak_after, weak_idx;
    int widths [64];
    int zc [64];
    logic [7:0] snap_a [64];
    logic [7:0] snap_b [64];
    int addr_a, addr_b;
    int exp_w [64];
    int exp_n;
    int checks = 0;
    int fails = 0;

    assign fl_rdata = mem[fl_addr];

    always @(negedge clk) begin
        if (done) done_cnt++;
        if (fl_wr) begin
            automatic int p = (wcount / PB < 64) ? wcount / PB : 63;
            lat[fl_addr] = fl_wdata;
            zc[p] += $countones(~fl_wdata);
            if ((~fl_wdata & tgt[fl_addr]) != 8'h00) viol++;
            if (int'(fl_addr) == addr_a) snap_a[p] = fl_wdata;
            if (int'(fl_addr) == addr_b) snap_b[p] = fl_wdata;
            wcount++;
        end
        if (fl_pulse) begin
            plen++;
        end else if (plen > 0) begin
            if (npulse < 64) widths[npulse] = plen;
            if (plen >= SH) begin
                for (int i = 0; i < PB*8; i++) begin
                    if (lat[i/8][i%8] == 1'b0) begin
                        got[i]++;
                        if (got[i] >= need[i]) mem[i/8][i%8] = 1'b0;
                    end
                end
            end
            npulse++;
            if (npulse == weak_after) begin
                mem[weak_idx/8][weak_idx%8] = 1'b1;
                got[weak_idx] = 0;
                need[weak_idx] = 1;
            end
            plen = 0;
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic prep();
        for (int i = 0; i < PB; i++) begin
            mem[i] = 8'hFF; lat[i] = 8'hFF; tgt[i] = 8'hFF;
        end
        for (int i = 0; i < PB*8; i++) begin
            need[i] = 1; got[i] = 0;
        end
        for (int i = 0; i < 64; i++) begin
            zc[i] = 0; widths[i] = 0; snap_a[i] = 8'hFF; snap_b[i] = 8'hFF;
        end
        plen = 0; npulse = 0; wcount = 0; viol = 0; done_cnt = 0;
        weak_after = -1; weak_idx = 0; addr_a = 0; addr_b = 0; exp_n = 0;
    endtask

    task automatic push_w(input int w);
        exp_w[exp_n] = w;
        exp_n++;
    endtask

    task automatic load_page();
        for (int a = 0; a < PB; a++) begin
            @(negedge clk);
            ld_en = 1'b1; ld_addr = AW'(a); ld_data = tgt[a];
        end
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic run_seq(input string req, output logic f);
        int n;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(busy === 1'b1, "R2", "busy after start", int'(busy), 1);
        n = 0;
        while (done !== 1'b1 && n < 40000) begin
            @(negedge clk); n++;
        end
        chk(done === 1'b1, req, "run reached done", int'(done), 1);
        f = fail;
        @(negedge clk);
        chk(done === 1'b0 && busy === 1'b0, "R2", "done one cycle then idle", int'({done, busy}), 0);
    endtask

    task automatic check_end(input string req, input logic f, input logic exp_f);
        chk(f === exp_f, req, "fail flag", int'(f), int'(exp_f));
        chk(npulse == exp_n, req, "pulse count", npulse, exp_n);
        for (int i = 0; i < exp_n; i++) begin
            if (widths[i] != exp_w[i]) chk(1'b0, req, $sformatf("pulse %0d width", i), widths[i], exp_w[i]);
        end
        chk(viol == 0, "R6", "target-one bits written as zero", viol, 0);
        if (!exp_f) begin
            int bad = 0;
            for (int i = 0; i < PB; i++) if (mem[i] !== tgt[i]) bad++;
            chk(bad == 0, "R10", "array equals target", bad, 0);
        end
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        chk(busy === 1'b0 && done === 1'b0 && fail === 1'b0, "R12", "status after reset",
            int'({busy, done, fail}), 0);
        chk(fl_wr === 1'b0 && fl_pulse === 1'b0, "R12", "array port after reset",
            int'({fl_wr, fl_pulse}), 0);
    endtask

    task automatic t_all_ones();
        logic f;
        prep();
        load_page();
        push_w(SH);
        run_seq("R10", f);
        check_end("R10", f, 1'b0);
        chk(zc[0] == 0, "R3", "empty latch image zeros", zc[0], 0);
    endtask

    task automatic t_early_mix();
        logic f;
        prep();
        tgt[0] = 8'hFE; need[0*8+0] = 1;
        tgt[1] = 8'hF7; need[1*8+3] = 2;
        tgt[2] = 8'h7F; need[2*8+7] = 3;
        addr_a = 0; addr_b = 1;
        load_page();
        push_w(SH); push_w(XT); push_w(SH); push_w(XT); push_w(SH); push_w(XT);
        fork
            run_seq("R7", f);
            begin
                repeat (40) @(negedge clk);
                ld_en = 1'b1; ld_addr = AW'(5); ld_data = 8'h00; start = 1'b1;
                @(negedge clk);
                ld_en = 1'b0; start = 1'b0;
            end
        join
        check_end("R7", f, 1'b0);
        chk(zc[0] == 3, "R3", "loop1 latch zeros equal target zeros", zc[0], 3);
        chk(zc[1] == 1 && snap_a[1] == 8'hFE, "R7", "extra image loop1", zc[1], 1);
        chk(zc[2] == 2, "R5", "loop2 latch zeros", zc[2], 2);
        chk(zc[3] == 1 && snap_b[3] == 8'hF7, "R7", "extra image loop2", zc[3], 1);
        chk(zc[5] == 1, "R10", "extra pass before done in final loop", zc[5], 1);
        chk(mem[5] == 8'hFF, "R1", "load while busy ignored", int'(mem[5]), 255);
        repeat (20) @(negedge clk);
        chk(done_cnt == 1, "R2", "start while busy ignored", done_cnt, 1);
    endtask

    task automatic t_late_loops();
        logic f;
        prep();
        tgt[0] = 8'hFE; need[0] = 2;
        tgt[3] = 8'hFD; need[3*8+1] = 8;
        load_page();
        push_w(SH); push_w(SH); push_w(XT); push_w(SH); push_w(SH); push_w(SH); push_w(SH);
        push_w(LG); push_w(LG);
        run_seq("R4", f);
        check_end("R4", f, 1'b0);
        chk(widths[8] == LG, "R8", "no extra pulse after late first verify", npulse, 9);
    endtask

    task automatic t_limit();
        logic f;
        int mains;
        prep();
        tgt[0] = 8'hFE; need[0] = 1;
        tgt[9] = 8'hEF; need[9*8+4] = 50;
        load_page();
        push_w(SH); push_w(XT);
        for (int i = 0; i < 5; i++) push_w(SH);
        for (int i = 0; i < 4; i++) push_w(LG);
        run_seq("R11", f);
        check_end("R11", f, 1'b1);
        mains = 0;
        for (int i = 0; i < npulse && i < 64; i++) if (widths[i] != XT) mains++;
        chk(mains == 10, "R11", "main pulses at limit", mains, 10);
    endtask

    task automatic t_regress();
        logic f;
        prep();
        tgt[4] = 8'hFB; need[4*8+2] = 1;
        tgt[20] = 8'hBF; need[20*8+6] = 4;
        addr_a = 4; addr_b = 20;
        weak_after = 3; weak_idx = 4*8+2;
        load_page();
        push_w(SH); push_w(XT); push_w(SH); push_w(SH); push_w(SH); push_w(XT);
        run_seq("R9", f);
        check_end("R9", f, 1'b0);
        chk(zc[2] == 1, "R5", "loop2 latch holds only pending bit", zc[2], 1);
        chk(snap_a[3] == 8'hFB && zc[3] == 2, "R9", "regressed bit pulsed again", int'(snap_a[3]), 251);
        chk(snap_a[5] == 8'hFF && snap_b[5] == 8'hBF, "R9", "no repeat extra for regressed bit",
            int'(snap_a[5]), 255);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        prep();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_all_ones();
        t_early_mix();
        t_late_loops();
        t_limit();
        t_regress();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule